// File: doc/BRIEF.md
# Pipeline Hazard Stall Unit

This unit decides, every cycle, whether a five-stage in-order pipeline may move its front end forward. The pipeline has no forwarding paths. It also shares one single-port main memory between instruction fetch and operand loads and stores. The surrounding pipeline presents the instruction that currently sits in the decode register: its source register numbers, its destination, whether it writes a register and whether it touches memory. From this the unit returns four controls. Two are hold enables for the fetch and decode registers. One inserts an empty slot into the execute stage. The fourth marks that the decode register receives nothing, because fetch gave up the memory port.

The unit keeps its own small shadow of the instructions it has let pass into execute and memory. It therefore needs no per-stage inputs from further down the pipe. Each stage takes one clock. The register file writes in the first half of writeback and reads in the second half of decode. As a result, a producer that has reached writeback no longer blocks a consumer, and a dependent pair issued back to back loses exactly two cycles. A parameter can select a register file without that split. In that case the writeback stage is also tracked and compared.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After synchronous active-low reset, the shadow holds no instructions, and no output is high for a decode instruction that arrives with any sources.
- R2: When an enabled source of a valid decode instruction equals the non-zero destination of a register-writing instruction now in execute or memory, decode_stall, fetch_stall and ex_bubble are all high in that same cycle.
- R3: With the default split-cycle register file, a consumer directly behind its producer stalls for exactly two cycles. With one unrelated instruction between them it stalls for one cycle, and with two or more between them it does not stall. decode_stall is never high for three cycles in a row.
- R4: Register number 0 never creates a dependency. A source whose enable is low never matches. A destination whose write enable is low never matches.
- R5: The slot inserted on a stall carries no destination and no memory access, so it never causes a later stall by itself.
- R6: In the cycle in which a valid memory-access instruction occupies the memory stage (two cycles after it leaves decode), fetch_stall is high. If there is no dependency stall at the same time, decode_bubble is also high.
- R7: The memory-port stall is evaluated on every cycle, separately from the dependency check. When both apply, fetch_stall, decode_stall and ex_bubble are high and decode_bubble is low. decode_bubble and decode_stall are never high together.
- R8: When id_valid is low, decode_stall and ex_bubble stay low, whatever the source fields hold.
- R9: Whenever decode_stall is high, fetch_stall and ex_bubble are high as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode register holds an instruction |
| id_src1 | input | 5 | First source register number |
| id_src1_en | input | 1 | First source is read |
| id_src2 | input | 5 | Second source register number |
| id_src2_en | input | 1 | Second source is read |
| id_dst | input | 5 | Destination register number |
| id_dst_en | input | 1 | Instruction writes its destination |
| id_mem_acc | input | 1 | Instruction performs a load or store |
| fetch_stall | output | 1 | Hold the fetch stage; it issues no memory request |
| decode_stall | output | 1 | Hold the decode register |
| ex_bubble | output | 1 | Load an empty slot into execute |
| decode_bubble | output | 1 | Decode register receives an empty slot next cycle |

## Verification
The shadow of execute and memory is the only state in the unit. A wrong shadow entry shows up at the ports within one or two cycles. A destination that is lost or stale either drops a required stall or stretches it, so the stall count for a dependent pair comes out other than two, one or zero. A memory flag that is misplaced moves fetch_stall one cycle away from the slot two cycles after the load or store left decode. A bubble that was not cleared makes phantom stalls appear behind it. The bench compares all four outputs against a behavioural queue on every cycle, so any of these faults is reported in the cycle it first reaches an output.

// File: rtl/hz_pkg.sv
// Package: shared sizes and the per-slot record of the hazard stall unit.
// Assumes a register file with 2**REG_AW entries where entry 0 is hard-wired.
package hz_pkg;
    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;

    // What the unit remembers about one instruction downstream of decode.
    typedef struct packed {
        logic              valid;
        logic              wr;
        logic              mem;
        logic [REG_AW-1:0] dst;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '{valid: 1'b0, wr: 1'b0, mem: 1'b0, dst: '0};
endpackage

// File: rtl/hz_shadow_pipe.sv
// Module: shadow copy of the stages after decode (execute, memory and,
// optionally, writeback). Entry 0 is execute. It advances every clock,
// because stages past decode never stall. Assumes synchronous active-low reset.
module hz_shadow_pipe
    import hz_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t enter_slot,
    output slot_t stage [DEPTH]
);
    // Execute entry: load what decode hands over, or empty on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= EMPTY_SLOT;
        else        stage[0] <= enter_slot;
    end

    // Later entries: plain shift register, one stage per clock.
    for (genvar i = 1; i < DEPTH; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= EMPTY_SLOT;
            else        stage[i] <= stage[i-1];
        end
    end
endmodule

// File: rtl/hz_raw_match.sv
// Module: read-after-write detector. Compares each enabled decode source
// against every tracked downstream destination that is valid, written and
// non-zero. Assumes the caller passes only the stages whose results are not
// yet readable from the register file.
module hz_raw_match
    import hz_pkg::*;
#(
    parameter int NCHK = 2
) (
    input  logic [REG_AW-1:0] src_num [NUM_SRC],
    input  logic              src_en  [NUM_SRC],
    input  slot_t             stage   [NCHK],
    output logic              hit
);
    logic [NCHK-1:0]    live;
    logic [NUM_SRC-1:0] pair [NCHK];

    for (genvar s = 0; s < NCHK; s++) begin : g_stage
        // A stage counts only if it will really write a non-zero register.
        assign live[s] = stage[s].valid && stage[s].wr && (stage[s].dst != '0);
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            // One source against one stage.
            assign pair[s][k] = live[s] && src_en[k] && (src_num[k] == stage[s].dst);
        end
    end

    // Reduce the comparison matrix to one hazard flag.
    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NCHK; s++) hit = hit | (|pair[s]);
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
// Module: combines the dependency flag and the memory-port conflict into the
// front-end controls. The port conflict always takes fetch off the memory,
// whether or not a dependency exists. Purely combinational.
module hz_stall_ctrl (
    input  logic id_valid,
    input  logic raw_hit,
    input  logic port_busy,
    output logic fetch_stall,
    output logic decode_stall,
    output logic ex_bubble,
    output logic decode_bubble
);
    logic raw_stall;

    // Decide the four front-end controls for this cycle.
    always_comb begin
        raw_stall     = id_valid && raw_hit;
        decode_stall  = raw_stall;
        ex_bubble     = raw_stall;
        fetch_stall   = raw_stall || port_busy;
        decode_bubble = port_busy && !raw_stall;
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
// Module: hazard stall unit for a five-stage in-order pipeline that has no
// forwarding and one single-port memory. Tracks the instructions it releases
// from decode and raises stalls for read-after-write dependencies and for
// memory-stage operand accesses. WB_WRITE_FIRST=1 assumes the register file
// writes before it reads within one cycle, so writeback needs no tracking.
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int WB_WRITE_FIRST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_src1,
    input  logic              id_src1_en,
    input  logic [REG_AW-1:0] id_src2,
    input  logic              id_src2_en,
    input  logic [REG_AW-1:0] id_dst,
    input  logic              id_dst_en,
    input  logic              id_mem_acc,
    output logic              fetch_stall,
    output logic              decode_stall,
    output logic              ex_bubble,
    output logic              decode_bubble
);
    localparam int NCHK = (WB_WRITE_FIRST != 0) ? 2 : 3;
    localparam int MEM_IDX = 1;

    slot_t             issue;
    slot_t             shadow [NCHK];
    logic [REG_AW-1:0] src_num [NUM_SRC];
    logic              src_en  [NUM_SRC];
    logic              raw_hit;
    logic              port_busy;

    // Gather the decode sources into arrays for the comparator.
    always_comb begin
        src_num[0] = id_src1;
        src_en[0]  = id_src1_en;
        src_num[1] = id_src2;
        src_en[1]  = id_src2_en;
    end

    // Record released to execute: the decode instruction, or an empty slot.
    always_comb begin
        issue       = EMPTY_SLOT;
        issue.valid = id_valid && !decode_stall;
        if (issue.valid) begin
            issue.wr  = id_dst_en;
            issue.mem = id_mem_acc;
            issue.dst = id_dst;
        end
    end

    // The memory stage owns the single port when it holds a load or store.
    always_comb port_busy = shadow[MEM_IDX].valid && shadow[MEM_IDX].mem;

    hz_shadow_pipe #(.DEPTH(NCHK)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_slot (issue),
        .stage      (shadow)
    );

    hz_raw_match #(.NCHK(NCHK)) u_raw (
        .src_num (src_num),
        .src_en  (src_en),
        .stage   (shadow),
        .hit     (raw_hit)
    );

    hz_stall_ctrl u_ctrl (
        .id_valid      (id_valid),
        .raw_hit       (raw_hit),
        .port_busy     (port_busy),
        .fetch_stall   (fetch_stall),
        .decode_stall  (decode_stall),
        .ex_bubble     (ex_bubble),
        .decode_bubble (decode_bubble)
    );
endmodule

// File: rtl/hz_checker.sv
// Module: property checker for pipe_hazard_unit, attached by bind. Keeps its
// own two-deep record of released memory accesses to time the port stall.
module hz_checker
    import hz_pkg::*;
#(
    parameter int WB_WRITE_FIRST = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              id_valid,
    input logic [REG_AW-1:0] id_src1,
    input logic              id_src1_en,
    input logic [REG_AW-1:0] id_src2,
    input logic              id_src2_en,
    input logic              id_mem_acc,
    input logic              fetch_stall,
    input logic              decode_stall,
    input logic              ex_bubble,
    input logic              decode_bubble
);
    logic       armed;
    logic [1:0] mem_age;

    // Track cycles since reset and where released memory accesses are.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            mem_age <= 2'b00;
        end else begin
            armed   <= 1'b1;
            mem_age <= {mem_age[0], id_valid && !decode_stall && id_mem_acc};
        end
    end

    a_r6_port_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_age[1]) |-> fetch_stall);

    a_r6_no_spurious_port: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fetch_stall && !decode_stall) |-> mem_age[1]);

    a_r9_stall_implies_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && decode_stall) |-> (fetch_stall && ex_bubble));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !(decode_stall && decode_bubble));

    a_r8_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !id_valid) |-> !decode_stall);

    a_r4_zero_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (!id_src1_en || id_src1 == '0) && (!id_src2_en || id_src2 == '0))
        |-> !decode_stall);

    if (WB_WRITE_FIRST != 0) begin : g_bound
        a_r3_two_cycle_limit: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(armed) && decode_stall && $past(decode_stall)) |=> !decode_stall);
    end
endmodule

bind pipe_hazard_unit hz_checker #(.WB_WRITE_FIRST(WB_WRITE_FIRST)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_valid      (id_valid),
    .id_src1       (id_src1),
    .id_src1_en    (id_src1_en),
    .id_src2       (id_src2),
    .id_src2_en    (id_src2_en),
    .id_mem_acc    (id_mem_acc),
    .fetch_stall   (fetch_stall),
    .decode_stall  (decode_stall),
    .ex_bubble     (ex_bubble),
    .decode_bubble (decode_bubble)
);

// File: tb/pipe_hazard_unit_test.sv
// Bench: a behavioural queue of released instructions predicts all outputs on
// every cycle; directed sequences count stall lengths and port conflicts.
module pipe_hazard_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [4:0] id_src1 = '0, id_src2 = '0, id_dst = '0;
    logic       id_src1_en = 1'b0, id_src2_en = 1'b0, id_dst_en = 1'b0, id_mem_acc = 1'b0;
    logic       fetch_stall, decode_stall, ex_bubble, decode_bubble;

    int checks = 0;
    int errors = 0;
    int obs_both = 0;
    int obs_port = 0;

    typedef struct { bit v; bit w; bit m; int d; } ent_t;
    ent_t q[$];

    always #4 clk = ~clk;

    pipe_hazard_unit uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_src1(id_src1), .id_src1_en(id_src1_en),
        .id_src2(id_src2), .id_src2_en(id_src2_en),
        .id_dst(id_dst), .id_dst_en(id_dst_en), .id_mem_acc(id_mem_acc),
        .fetch_stall(fetch_stall), .decode_stall(decode_stall),
        .ex_bubble(ex_bubble), .decode_bubble(decode_bubble)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Present one instruction in decode until it is released; returns stall count.
    task automatic present(input bit v, input int s1, input bit e1, input int s2, input bit e2,
                           input int d, input bit de, input bit m, output int stalls);
        bit raw, prt;
        stalls = 0;
        forever begin
            @(negedge clk);
            id_valid = v; id_src1 = 5'(s1); id_src1_en = e1; id_src2 = 5'(s2);
            id_src2_en = e2; id_dst = 5'(d); id_dst_en = de; id_mem_acc = m;
            #3;
            raw = 0;
            if (v) for (int i = 0; i < 2 && i < q.size(); i++)
                if (q[i].v && q[i].w && q[i].d != 0 && ((e1 && s1 == q[i].d) || (e2 && s2 == q[i].d)))
                    raw = 1;
            prt = (q.size() > 1) && q[1].v && q[1].m;
            check("R2 decode_stall", decode_stall, raw);
            check("R9 ex_bubble", ex_bubble, raw);
            check("R6 fetch_stall", fetch_stall, raw | prt);
            check("R7 decode_bubble", decode_bubble, prt & !raw);
            if (fetch_stall && decode_stall && !decode_bubble && prt) obs_both++;
            if (fetch_stall && decode_bubble) obs_port++;
            @(posedge clk);
            q.push_front('{v: v && !raw, w: de && v && !raw, m: m && v && !raw, d: d});
            while (q.size() > 2) void'(q.pop_back());
            if (!raw) break;
            stalls++;
        end
    endtask

    task automatic idle(input int n);
        int st;
        for (int i = 0; i < n; i++) present(0, 0, 0, 0, 0, 0, 0, 0, st);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int st;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: fresh state, valid instruction with enabled sources, nothing asserted.
        @(negedge clk);
        id_valid = 1; id_src1 = 5; id_src1_en = 1; id_src2 = 6; id_src2_en = 1;
        #3;
        check("R1 reset stalls", {fetch_stall, decode_stall, ex_bubble, decode_bubble}, 0);
        @(posedge clk);
        q.push_front('{v: 1, w: 0, m: 0, d: 0});

        // R3: back-to-back pair stalls two cycles.
        idle(3);
        present(1, 0, 0, 0, 0, 3, 1, 0, st);
        present(1, 3, 1, 0, 0, 9, 1, 0, st);
        check("R3 distance one stalls", st, 2);
        // R5: the inserted bubbles cause no extra stall for a follower of r9.
        present(1, 1, 1, 0, 0, 12, 1, 0, st);
        check("R5 bubble inert", st, 0);

        // R3: one unrelated instruction between.
        idle(3);
        present(1, 0, 0, 0, 0, 4, 1, 0, st);
        present(1, 0, 0, 0, 0, 13, 1, 0, st);
        present(1, 0, 0, 4, 1, 14, 1, 0, st);
        check("R3 distance two stalls", st, 1);

        // R3: two unrelated instructions between.
        idle(3);
        present(1, 0, 0, 0, 0, 6, 1, 0, st);
        present(1, 0, 0, 0, 0, 15, 1, 0, st);
        present(1, 0, 0, 0, 0, 16, 1, 0, st);
        present(1, 6, 1, 0, 0, 17, 1, 0, st);
        check("R3 distance three stalls", st, 0);

        // R4: register zero, disabled write, disabled source.
        idle(3);
        present(1, 0, 0, 0, 0, 0, 1, 0, st);
        present(1, 0, 1, 0, 1, 18, 1, 0, st);
        check("R4 zero register", st, 0);
        idle(3);
        present(1, 0, 0, 0, 0, 7, 0, 0, st);
        present(1, 7, 1, 7, 1, 19, 1, 0, st);
        check("R4 write disabled", st, 0);
        idle(3);
        present(1, 0, 0, 0, 0, 8, 1, 0, st);
        present(1, 8, 0, 0, 0, 20, 1, 0, st);
        check("R4 source disabled", st, 0);

        // R8: empty decode slot with matching fields does not stall.
        idle(3);
        present(1, 0, 0, 0, 0, 10, 1, 0, st);
        present(0, 10, 1, 10, 1, 0, 0, 0, st);
        check("R8 idle slot", st, 0);

        // R6: memory access occupies the port two cycles after release.
        idle(3);
        obs_port = 0;
        present(1, 0, 0, 0, 0, 11, 1, 1, st);
        present(1, 0, 0, 0, 0, 21, 1, 0, st);
        check("R6 no port stall in execute", obs_port, 0);
        present(1, 0, 0, 0, 0, 22, 1, 0, st);
        check("R6 port stall in memory stage", obs_port, 1);

        // R7: load followed by its consumer: both stalls coincide.
        idle(3);
        obs_both = 0;
        present(1, 0, 0, 0, 0, 23, 1, 1, st);
        present(1, 0, 0, 23, 1, 24, 1, 0, st);
        check("R7 load-use stalls", st, 2);
        check("R7 combined cycle seen", obs_both, 1);

        // Mixed random traffic over a small register range.
        idle(3);
        for (int i = 0; i < 400; i++) begin
            present($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 1) != 0,
                    $urandom_range(0, 3), $urandom_range(0, 1) != 0, $urandom_range(0, 3),
                    $urandom_range(0, 1) != 0, $urandom_range(0, 2) == 0, st);
        end
        finish_run();
    end
endmodule